// File: doc/BRIEF.md
# ADC Window Compare Event Filter

This block sits behind an analog-to-digital converter and watches the stream of finished conversions. Each conversion arrives with a valid strobe, a sample value and the number of the channel it came from. The block compares each sample against a programmable low threshold and a programmable high threshold, using one of four window modes. A sample can count as a compare event only if its channel is selected. The selection is either one chosen channel or every channel.

A programmable filter requires a run of matching samples in a row before anything is reported. When the run completes, the block sets a sticky flag and produces a one-cycle event pulse. The flag stays set until a clear pulse arrives. The configuration is captured from a write strobe only while the write-protect input is low. Software would typically lock the settings once the comparison is armed.

Top module: `smpl_window_watch`

## Requirements
- R1: After synchronous active-low reset, `flag_o` and `event_o` are 0 and the run counter is empty.
- R2: Mode 0 (below) counts a compared sample as a match when sample < low threshold. A sample equal to the low threshold does not match.
- R3: Mode 1 (above) counts a compared sample as a match when sample > high threshold. A sample equal to the high threshold does not match.
- R4: Mode 2 (inside) matches when low ≤ sample ≤ high, with both limits included.
- R5: Mode 3 (outside) matches when sample < low or sample > high. This is the exact complement of mode 2.
- R6: With `cfg_all` = 0, only samples whose channel equals `cfg_chan` are compared. Samples from any other channel leave the run counter unchanged, whatever their value.
- R7: With `cfg_all` = 1, samples from every channel are compared and `cfg_chan` has no effect.
- R8: The flag is raised on the (`cfg_filt`+1)-th consecutive match, where `cfg_filt` is a 2-bit count from 0 to 3. With a count of 0, the first match raises it.
- R9: A compared sample that does not match empties the run counter.
- R10: At each raise the counter restarts from zero, and `event_o` is high for exactly the cycle that follows the completing sample.
- R11: `flag_o` stays set until `flag_clr` is asserted. When a raise and a clear occur in the same cycle, the raise wins.
- R12: A configuration write (`cfg_we`) takes effect from the next cycle only if `cfg_lock` is low. A write made while `cfg_lock` is high is ignored.
- R13: Cycles with `smp_valid` low neither count nor break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lock | input | 1 | Write protect; writes are ignored while high |
| cfg_low | input | SMP_W | Low threshold |
| cfg_high | input | SMP_W | High threshold |
| cfg_mode | input | 2 | Window mode: 0 below, 1 above, 2 inside, 3 outside |
| cfg_chan | input | CH_W | Selected channel when cfg_all is 0 |
| cfg_all | input | 1 | Compare samples from all channels |
| cfg_filt | input | 2 | Consecutive matches needed, minus one |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W | Sample value |
| smp_chan | input | CH_W | Channel of the sample |
| flag_clr | input | 1 | Clears the sticky flag |
| flag_o | output | 1 | Sticky compare flag |
| event_o | output | 1 | One-cycle pulse on each raise |

## Verification
The bench drives samples that sit exactly on each threshold. A design that used the wrong strictness would fire on a sample it should ignore, or miss one it should report. It interleaves samples from channels that are not selected with matching runs. If such samples reset the run or added to it, the event would come early or late. It also sends a breaking sample in the middle of a run, a raise that lands together with a clear, and a configuration write while the lock is held. Each of these shows up at the ports as a flag or pulse on the wrong cycle, or as a missing one.

// File: rtl/swin_pkg.sv
// Shared types for the sample window watcher.
// Assumes: nothing beyond IEEE 1800-2017.
package swin_pkg;
    // Window comparison kinds; the encoding is the value of the mode field.
    typedef enum logic [1:0] {
        CMP_BELOW   = 2'd0,
        CMP_ABOVE   = 2'd1,
        CMP_INSIDE  = 2'd2,
        CMP_OUTSIDE = 2'd3
    } cmp_mode_e;

    localparam int FILT_W = 2;
endpackage

// File: rtl/swin_cfg_bank.sv
// Holds the comparison settings. Captures the inputs on a write strobe only
// while the write-protect input is low.
// Assumes: the settings are stable while they are being written.
module swin_cfg_bank
    import swin_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int CH_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [SMP_W-1:0]  low_d,
    input  logic [SMP_W-1:0]  high_d,
    input  logic [1:0]        mode_d,
    input  logic [CH_W-1:0]   chan_d,
    input  logic              all_d,
    input  logic [FILT_W-1:0] filt_d,
    output logic [SMP_W-1:0]  low_q,
    output logic [SMP_W-1:0]  high_q,
    output cmp_mode_e         mode_q,
    output logic [CH_W-1:0]   chan_q,
    output logic              all_q,
    output logic [FILT_W-1:0] filt_q
);
    logic accept;
    assign accept = wr_en & ~wr_lock;

    // Purpose: capture an unprotected configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
            mode_q <= CMP_BELOW;
            chan_q <= '0;
            all_q  <= 1'b0;
            filt_q <= '0;
        end else if (accept) begin
            low_q  <= low_d;
            high_q <= high_d;
            mode_q <= cmp_mode_e'(mode_d);
            chan_q <= chan_d;
            all_q  <= all_d;
            filt_q <= filt_d;
        end
    end
endmodule

// File: rtl/swin_match.sv
// Decides whether the current sample is compared, and whether it falls in
// the region that the mode selects. Purely combinational.
// Assumes: the thresholds are unsigned and are taken as given (low may exceed high).
module swin_match
    import swin_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int CH_W  = 4
) (
    input  logic             valid,
    input  logic [SMP_W-1:0] data,
    input  logic [CH_W-1:0]  chan,
    input  logic [SMP_W-1:0] low_q,
    input  logic [SMP_W-1:0] high_q,
    input  cmp_mode_e        mode_q,
    input  logic [CH_W-1:0]  chan_q,
    input  logic             all_q,
    output logic             cmp_en,
    output logic             cmp_hit
);
    logic below, above;

    // Purpose: qualify the sample by channel selection.
    always_comb begin
        cmp_en = valid & (all_q | (chan == chan_q));
    end

    // Purpose: evaluate the window condition for the programmed mode.
    always_comb begin
        below = data < low_q;
        above = data > high_q;
        unique case (mode_q)
            CMP_BELOW:   cmp_hit = below;
            CMP_ABOVE:   cmp_hit = above;
            CMP_INSIDE:  cmp_hit = ~below & ~above;
            CMP_OUTSIDE: cmp_hit = below | above;
            default:     cmp_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/swin_filter.sv
// Counts consecutive matches. Raises the sticky flag and a one-cycle pulse
// when the run reaches the filter count plus one.
// Assumes: cmp_en and cmp_hit are stable around the clock edge.
module swin_filter
    import swin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic              cmp_hit,
    input  logic [FILT_W-1:0] filt_q,
    input  logic              clr,
    output logic              flag_o,
    output logic              event_o
);
    logic [FILT_W-1:0] run_cnt;
    logic              raise;

    // Purpose: detect the match that completes a run (>= tolerates a lowered count).
    always_comb begin
        raise = cmp_en & cmp_hit & (run_cnt >= filt_q);
    end

    // Purpose: advance or empty the run counter, and update the flag and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            flag_o  <= 1'b0;
            event_o <= 1'b0;
        end else begin
            event_o <= raise;
            flag_o  <= raise | (flag_o & ~clr);
            if (cmp_en) begin
                run_cnt <= (cmp_hit && !raise) ? run_cnt + 1'b1 : '0;
            end
        end
    end
endmodule

// File: rtl/smpl_window_watch.sv
// Top level: a configuration bank, the window matcher and the run filter.
// Assumes: one sample per cycle at most; the channel width fits CH_NUM.
module smpl_window_watch
    import swin_pkg::*;
#(
    parameter int SMP_W  = 12,
    parameter int CH_NUM = 16,
    localparam int CH_W  = (CH_NUM > 1) ? $clog2(CH_NUM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_lock,
    input  logic [SMP_W-1:0]  cfg_low,
    input  logic [SMP_W-1:0]  cfg_high,
    input  logic [1:0]        cfg_mode,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_all,
    input  logic [FILT_W-1:0] cfg_filt,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [CH_W-1:0]   smp_chan,
    input  logic              flag_clr,
    output logic              flag_o,
    output logic              event_o
);
    localparam int SNAP_W = 2*SMP_W + 2 + CH_W + 1 + FILT_W;

    logic [SMP_W-1:0]  low_q, high_q;
    cmp_mode_e         mode_q;
    logic [CH_W-1:0]   chan_q;
    logic              all_q;
    logic [FILT_W-1:0] filt_q;
    logic              cmp_en, cmp_hit;

    swin_cfg_bank #(.SMP_W(SMP_W), .CH_W(CH_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_lock(cfg_lock),
        .low_d(cfg_low), .high_d(cfg_high), .mode_d(cfg_mode),
        .chan_d(cfg_chan), .all_d(cfg_all), .filt_d(cfg_filt),
        .low_q(low_q), .high_q(high_q), .mode_q(mode_q),
        .chan_q(chan_q), .all_q(all_q), .filt_q(filt_q)
    );

    swin_match #(.SMP_W(SMP_W), .CH_W(CH_W)) u_match (
        .valid(smp_valid), .data(smp_data), .chan(smp_chan),
        .low_q(low_q), .high_q(high_q), .mode_q(mode_q),
        .chan_q(chan_q), .all_q(all_q),
        .cmp_en(cmp_en), .cmp_hit(cmp_hit)
    );

    swin_filter u_filt (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_hit(cmp_hit),
        .filt_q(filt_q), .clr(flag_clr), .flag_o(flag_o), .event_o(event_o)
    );
endmodule

// File: rtl/swin_chk.sv
// Checker for smpl_window_watch, attached with bind below.
module swin_chk #(
    parameter int SNAP_W = 34,
    parameter int FW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_lock,
    input logic              smp_valid,
    input logic              flag_clr,
    input logic              flag_o,
    input logic              event_o,
    input logic              cmp_en,
    input logic              cmp_hit,
    input logic [FW-1:0]     filt_q,
    input logic [SNAP_W-1:0] cfg_snap
);
    assert_lock_holds_cfg_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock || !cfg_we) |=> $stable(cfg_snap));

    assert_event_needs_sample_R13: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> $past(smp_valid));

    assert_event_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> flag_o);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr) |=> flag_o);

    assert_clear_unless_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!flag_o || event_o));

    assert_zero_filter_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cmp_hit && filt_q == '0) |=> event_o);

    assert_miss_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !cmp_hit) |=> !event_o);
endmodule

bind smpl_window_watch swin_chk #(.SNAP_W(SNAP_W), .FW(swin_pkg::FILT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lock(cfg_lock),
    .smp_valid(smp_valid), .flag_clr(flag_clr), .flag_o(flag_o),
    .event_o(event_o), .cmp_en(cmp_en), .cmp_hit(cmp_hit), .filt_q(filt_q),
    .cfg_snap({low_q, high_q, mode_q, chan_q, all_q, filt_q})
);

// File: tb/sim_smpl_window_watch.sv
module sim_smpl_window_watch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_lock = 0, cfg_all = 0;
    logic [11:0] cfg_low = 0, cfg_high = 0, smp_data = 0;
    logic [1:0]  cfg_mode = 0, cfg_filt = 0;
    logic [3:0]  cfg_chan = 0, smp_chan = 0;
    logic        smp_valid = 0, flag_clr = 0;
    logic        flag_o, event_o;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    smpl_window_watch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lock(cfg_lock),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_mode(cfg_mode),
        .cfg_chan(cfg_chan), .cfg_all(cfg_all), .cfg_filt(cfg_filt),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
        .flag_clr(flag_clr), .flag_o(flag_o), .event_o(event_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic setcfg(input logic [11:0] lo, input logic [11:0] hi, input logic [1:0] md,
                          input logic [3:0] ch, input logic all, input logic [1:0] flt);
        cfg_low = lo; cfg_high = hi; cfg_mode = md; cfg_chan = ch; cfg_all = all; cfg_filt = flt;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [11:0] d, input logic [3:0] ch);
        smp_valid = 1'b1; smp_data = d; smp_chan = ch;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle();
        smp_data = 12'd50; smp_chan = 4'd3;
        @(negedge clk);
    endtask

    task automatic clear();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "flag after reset", flag_o, 1'b0);
        chk("R1", "event after reset", event_o, 1'b0);
    endtask

    task automatic t_below();
        setcfg(12'd100, 12'd200, 2'd0, 4'd0, 1'b1, 2'd0);
        push(12'd100, 4'd1); chk("R2", "equal to low", event_o, 1'b0);
        push(12'd99, 4'd1);  chk("R2", "below low", event_o, 1'b1);
        chk("R2", "flag set", flag_o, 1'b1);
        clear();
    endtask

    task automatic t_above();
        setcfg(12'd100, 12'd200, 2'd1, 4'd0, 1'b1, 2'd0);
        push(12'd200, 4'd1); chk("R3", "equal to high", event_o, 1'b0);
        push(12'd201, 4'd1); chk("R3", "above high", event_o, 1'b1);
        clear();
    endtask

    task automatic t_inside();
        setcfg(12'd100, 12'd200, 2'd2, 4'd0, 1'b1, 2'd0);
        push(12'd100, 4'd1); chk("R4", "at low edge", event_o, 1'b1);
        push(12'd200, 4'd1); chk("R4", "at high edge", event_o, 1'b1);
        push(12'd99, 4'd1);  chk("R4", "below window", event_o, 1'b0);
        push(12'd201, 4'd1); chk("R4", "above window", event_o, 1'b0);
        clear();
    endtask

    task automatic t_outside();
        setcfg(12'd100, 12'd200, 2'd3, 4'd0, 1'b1, 2'd0);
        push(12'd150, 4'd1); chk("R5", "mid window", event_o, 1'b0);
        push(12'd100, 4'd1); chk("R5", "at low edge", event_o, 1'b0);
        push(12'd99, 4'd1);  chk("R5", "below low", event_o, 1'b1);
        push(12'd201, 4'd1); chk("R5", "above high", event_o, 1'b1);
        clear();
    endtask

    task automatic t_filter();
        setcfg(12'd100, 12'd200, 2'd0, 4'd0, 1'b1, 2'd2);
        push(12'd150, 4'd1);
        push(12'd50, 4'd1); push(12'd50, 4'd1);
        chk("R8", "two of three", flag_o, 1'b0);
        push(12'd150, 4'd1);
        push(12'd50, 4'd1); push(12'd50, 4'd1);
        chk("R9", "run broken by miss", flag_o, 1'b0);
        push(12'd50, 4'd1);
        chk("R8", "third match raises", event_o, 1'b1);
        chk("R8", "flag raised", flag_o, 1'b1);
        idle();
        chk("R10", "pulse lasts one cycle", event_o, 1'b0);
        push(12'd50, 4'd1); push(12'd50, 4'd1);
        chk("R10", "counter restarted", event_o, 1'b0);
        push(12'd50, 4'd1);
        chk("R10", "second run completes", event_o, 1'b1);
        clear();
        setcfg(12'd100, 12'd200, 2'd0, 4'd0, 1'b1, 2'd3);
        push(12'd150, 4'd1);
        for (int i = 0; i < 3; i++) push(12'd50, 4'd1);
        chk("R8", "three of four", flag_o, 1'b0);
        push(12'd50, 4'd1);
        chk("R8", "fourth match raises", event_o, 1'b1);
        clear();
    endtask

    task automatic t_chan();
        setcfg(12'd100, 12'd200, 2'd0, 4'd3, 1'b0, 2'd1);
        push(12'd150, 4'd3);
        push(12'd50, 4'd5);  chk("R6", "other channel match", event_o, 1'b0);
        push(12'd50, 4'd3);  chk("R6", "one selected match", event_o, 1'b0);
        push(12'd150, 4'd5); chk("R6", "other channel miss", event_o, 1'b0);
        push(12'd50, 4'd3);  chk("R6", "run survives other channel", event_o, 1'b1);
        clear();
    endtask

    task automatic t_all();
        setcfg(12'd100, 12'd200, 2'd0, 4'd3, 1'b1, 2'd0);
        push(12'd50, 4'd9);  chk("R7", "unselected channel compared", event_o, 1'b1);
        clear();
    endtask

    task automatic t_invalid();
        setcfg(12'd100, 12'd200, 2'd0, 4'd0, 1'b1, 2'd1);
        push(12'd150, 4'd1);
        idle(); chk("R13", "invalid match ignored", event_o, 1'b0);
        push(12'd50, 4'd1);
        smp_data = 12'd150; @(negedge clk);
        chk("R13", "invalid miss", event_o, 1'b0);
        push(12'd50, 4'd1);
        chk("R13", "run survives invalid cycle", event_o, 1'b1);
        clear();
    endtask

    task automatic t_sticky();
        setcfg(12'd100, 12'd200, 2'd0, 4'd0, 1'b1, 2'd0);
        push(12'd50, 4'd1);
        for (int i = 0; i < 4; i++) idle();
        chk("R11", "flag held while idle", flag_o, 1'b1);
        flag_clr = 1'b1;
        push(12'd50, 4'd1);
        flag_clr = 1'b0;
        chk("R11", "raise beats clear", flag_o, 1'b1);
        clear();
        chk("R11", "clear drops flag", flag_o, 1'b0);
    endtask

    task automatic t_lock();
        setcfg(12'd100, 12'd200, 2'd0, 4'd0, 1'b1, 2'd0);
        cfg_lock = 1'b1;
        setcfg(12'd100, 12'd200, 2'd1, 4'd0, 1'b1, 2'd0);
        push(12'd50, 4'd1);
        chk("R12", "locked write ignored", event_o, 1'b1);
        clear();
        cfg_lock = 1'b0;
        setcfg(12'd100, 12'd200, 2'd1, 4'd0, 1'b1, 2'd0);
        push(12'd50, 4'd1);
        chk("R12", "unlocked write applied", event_o, 1'b0);
        push(12'd250, 4'd1);
        chk("R12", "new mode active", event_o, 1'b1);
        clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_below();
        t_above();
        t_inside();
        t_outside();
        t_filter();
        t_chan();
        t_all();
        t_invalid();
        t_sticky();
        t_lock();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule